// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

A 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. It understands seven instructions: register add and subtract, OR with an immediate, word load, word store, branch-if-equal and an absolute jump. Every instruction that reaches a register or memory is committed on the rising edge that ends its cycle. The core holds a 32-entry register file, an immediate extender, a three-function ALU with a zero flag, and small word-addressed instruction and data memories.

Before a run, the memories are filled through a plain load port while reset is held. A fixed decoder sets, for each instruction, the write-back register (rd or rt), the second ALU operand (register or immediate), the extension mode (zero or sign) and the write-back source (ALU or memory). The branch decision comes straight from the ALU zero flag. A commit trace shows each register write and each store while its instruction is executing. A debug read port returns any register. The core has no streaming interface, so there is no back-pressure: it executes one instruction every cycle once reset is released.

Top module: `sc_core`

## Requirements
- R1: Instructions are decoded from op = bits [31:26]. R-type uses op 0x00 with funct in bits [5:0], where 0x20 is add and 0x22 is subtract. Among the I-type opcodes, 0x0D is or-immediate, 0x23 is load and 0x2B is store. The remaining opcodes are 0x04 for branch-if-equal and 0x02 for jump. The fields are rs [25:21], rt [20:16], rd [15:11], imm [15:0] and target [25:0].
- R2: A synchronous reset sets the PC to 0 and clears every register. While reset is high, no execution write takes place.
- R3: Register 0 always reads as zero, and a write aimed at it is dropped.
- R4: Or-immediate writes R[rs] OR the zero-extended imm into R[rt].
- R5: Add and subtract write R[rs]+R[rt] or R[rs]-R[rt] into R[rd].
- R6: Load writes into R[rt] the data word at R[rs] + sign-extended imm. Memories are word-addressed by address bits [7:2] at the default depth.
- R7: Store writes R[rt] to the data word at R[rs] + sign-extended imm and writes no register.
- R8: Branch-if-equal goes to PC+4 + (sign-extended imm << 2) when R[rs] equals R[rt], and to PC+4 otherwise. It writes nothing.
- R9: Jump goes to {PC+4 bits [31:28], target, 2'b00} and writes nothing.
- R10: An opcode outside the set, or an R-type with an unknown funct, writes nothing and advances the PC by 4.
- R11: The commit trace shows wb_valid with index and value, and st_valid with address and data, during the cycle of the committing instruction. No pulse appears for a write to register 0.
- R12: The load port writes the data memory when ld_dmem=1 and the instruction memory when ld_dmem=0, at word ld_addr, on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Memory load strobe |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | LD_AW | Word index for the load |
| ld_data | input | 32 | Word to load |
| dbg_idx | input | 5 | Register to read on the debug port |
| dbg_value | output | 32 | Debug register value |
| pc_o | output | 32 | Current program counter |
| wb_valid | output | 1 | A register write commits this cycle |
| wb_idx | output | 5 | Destination register |
| wb_value | output | 32 | Value written |
| st_valid | output | 1 | A store commits this cycle |
| st_addr | output | 32 | Store byte address |
| st_value | output | 32 | Stored word |

## Verification
One program runs the core through every instruction kind, and its committed writes are compared in order against a queue of expected results.

- The immediate 0x8001 shows whether or-immediate zero-extends.
- A load with offset 0xFFFC shows whether address offsets sign-extend.
- Add and subtract, with rt differing from rd, show which destination the decoder selects.
- A not-taken and a taken branch show whether the zero flag really decides the branch.
- A jump over code, followed by unknown encodings, shows that skipped or undefined instructions leave no write behind. This is confirmed by reading the registers they named through the debug port.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XW = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    src_imm;
    logic    wb_mem;
    logic    reg_we;
    logic    mem_we;
    logic    sext;
    logic    branch;
    logic    jump;
    alu_op_e alu;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_we = 1'b1;
          ctrl.alu    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl.src_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.alu     = ALU_OR;
      end
      OP_LW: begin
        ctrl.src_imm = 1'b1;
        ctrl.sext    = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_we  = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.sext    = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.sext   = 1'b1;
        ctrl.branch = 1'b1;
        ctrl.alu    = ALU_SUB;
      end
      OP_J: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_immext.sv
module sc_immext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  imm,
  input  logic             sext,
  output logic [OUT_W-1:0] ext
);
  localparam int PAD_W = OUT_W - IN_W;
  logic fill;
  assign fill = sext & imm[IN_W-1];
  assign ext  = {{PAD_W{fill}}, imm};
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*W-1:0]  rdata
);
  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [AW-1:0] ra;
    assign ra = raddr[p*AW +: AW];
    assign rdata[p*W +: W] = (ra == '0) ? '0 : regs[ra];
  end
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LD_AW      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [XW-1:0]    ld_data,
  input  logic [4:0]       dbg_idx,
  output logic [XW-1:0]    dbg_value,
  output logic [XW-1:0]    pc_o,
  output logic             wb_valid,
  output logic [4:0]       wb_idx,
  output logic [XW-1:0]    wb_value,
  output logic             st_valid,
  output logic [XW-1:0]    st_addr,
  output logic [XW-1:0]    st_value
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XW-1:0] pc, pc_next, pc_plus4, br_target, j_target;
  logic [XW-1:0] instr;
  logic [5:0]    opcode, funct;
  logic [4:0]    rs, rt, rd, dest;
  logic [15:0]   imm;
  logic [25:0]   target;
  ctrl_t         ctrl;
  logic [XW-1:0] ext, rdata_a, rdata_b, alu_b, alu_y, dmem_rdata, wb_data;
  logic          zero;
  logic          do_reg_we, do_mem_we;
  logic [3*5-1:0]  rf_raddr;
  logic [3*XW-1:0] rf_rdata;

  // Instruction fetch.
  sc_wordmem #(.WIDTH(XW), .DEPTH(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (ld_en & ~ld_dmem),
    .waddr (ld_addr[IAW-1:0]),
    .wdata (ld_data),
    .raddr (pc[IAW+1:2]),
    .rdata (instr)
  );

  // Field split.
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign imm    = instr[15:0];
  assign funct  = instr[5:0];
  assign target = instr[25:0];

  sc_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  assign dest      = ctrl.dst_rd ? rd : rt;
  assign do_reg_we = ctrl.reg_we & ~rst;
  assign do_mem_we = ctrl.mem_we & ~rst;

  assign rf_raddr = {dbg_idx, rt, rs};
  sc_regfile #(.W(XW), .NREGS(32), .NRD(3)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (do_reg_we),
    .waddr (dest),
    .wdata (wb_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );
  assign rdata_a   = rf_rdata[0*XW +: XW];
  assign rdata_b   = rf_rdata[1*XW +: XW];
  assign dbg_value = rf_rdata[2*XW +: XW];

  sc_immext #(.IN_W(16), .OUT_W(XW)) u_ext (
    .imm  (imm),
    .sext (ctrl.sext),
    .ext  (ext)
  );

  assign alu_b = ctrl.src_imm ? ext : rdata_b;

  sc_alu #(.W(XW)) u_alu (
    .a    (rdata_a),
    .b    (alu_b),
    .op   (ctrl.alu),
    .y    (alu_y),
    .zero (zero)
  );

  // Data memory: the load port takes the write port when it is strobed.
  logic            dm_we;
  logic [DAW-1:0]  dm_waddr;
  logic [XW-1:0]   dm_wdata;
  assign dm_we    = (ld_en & ld_dmem) | do_mem_we;
  assign dm_waddr = (ld_en & ld_dmem) ? ld_addr[DAW-1:0] : alu_y[DAW+1:2];
  assign dm_wdata = (ld_en & ld_dmem) ? ld_data : rdata_b;

  sc_wordmem #(.WIDTH(XW), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DAW+1:2]),
    .rdata (dmem_rdata)
  );

  assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;

  // Next PC.
  assign pc_plus4  = pc + XW'(4);
  assign br_target = pc_plus4 + {ext[XW-3:0], 2'b00};
  assign j_target  = {pc_plus4[XW-1:XW-4], target, 2'b00};

  always_comb begin
    if (ctrl.jump)              pc_next = j_target;
    else if (ctrl.branch & zero) pc_next = br_target;
    else                        pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  // Commit trace.
  assign pc_o     = pc;
  assign wb_valid = do_reg_we & (dest != 5'd0);
  assign wb_idx   = dest;
  assign wb_value = wb_data;
  assign st_valid = do_mem_we;
  assign st_addr  = alu_y;
  assign st_value = rdata_b;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        wb_valid,
  input logic [4:0]  wb_idx,
  input logic        st_valid,
  input logic [5:0]  opcode
);
  logic known_op;
  assign known_op = (opcode == 6'h00) || (opcode == 6'h0D) || (opcode == 6'h23) ||
                    (opcode == 6'h2B) || (opcode == 6'h04) || (opcode == 6'h02);

  // R2
  p_pc_cleared_r2: assert property (@(posedge clk) rst |=> pc == 32'd0);

  // R3 / R11
  p_no_zero_reg_commit_r3: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_idx != 5'd0);

  // R7
  p_store_only_from_sw_r7: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (opcode == 6'h2B && !wb_valid));

  // R8 / R9
  p_control_flow_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (opcode == 6'h04 || opcode == 6'h02) |-> (!wb_valid && !st_valid));

  // R10
  p_unknown_op_steps_r10: assert property (@(posedge clk) disable iff (rst)
    !known_op |=> pc == $past(pc) + 32'd4);

  // R10
  p_unknown_op_silent_r10: assert property (@(posedge clk) disable iff (rst)
    !known_op |-> (!wb_valid && !st_valid));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_o),
  .wb_valid (wb_valid),
  .wb_idx   (wb_idx),
  .st_valid (st_valid),
  .opcode   (instr[31:26])
);

// File: tb/sc_core_tb.sv
module sc_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0, ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_idx = '0;
  logic [31:0] dbg_value, pc_o, wb_value, st_addr, st_value;
  logic        wb_valid, st_valid;
  logic [4:0]  wb_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_idx(dbg_idx), .dbg_value(dbg_value), .pc_o(pc_o),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_value(wb_value),
    .st_valid(st_valid), .st_addr(st_addr), .st_value(st_value)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit monitoring = 0;

  typedef struct packed {
    logic        is_store;
    logic [31:0] a;
    logic [31:0] v;
  } exp_t;
  exp_t  exp_q[$];
  string req_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_w(input logic [4:0] idx, input logic [31:0] val, input string req);
    exp_q.push_back('{1'b0, {27'd0, idx}, val});
    req_q.push_back(req);
  endtask

  task automatic push_s(input logic [31:0] addr, input logic [31:0] val, input string req);
    exp_q.push_back('{1'b1, addr, val});
    req_q.push_back(req);
  endtask

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic load(input logic d, input int a, input logic [31:0] v);
    @(posedge clk); #1;
    ld_en = 1'b1; ld_dmem = d; ld_addr = a[5:0]; ld_data = v;
  endtask

  task automatic peek(input logic [4:0] idx, input logic [31:0] exp, input string req);
    dbg_idx = idx;
    #1;
    chk(req, dbg_value, exp);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Monitor: pop the expected commit queue as commits appear.
  always @(negedge clk) begin
    if (monitoring && !rst) begin
      if (wb_valid) begin
        if (exp_q.size() == 0 || exp_q[0].is_store) begin
          total++; bad++;
          $display("FAIL R11: unexpected write actual=r%0d:%h expected=none", wb_idx, wb_value);
        end else begin
          chk({req_q[0], " idx"}, {27'd0, wb_idx}, exp_q[0].a);
          chk({req_q[0], " value"}, wb_value, exp_q[0].v);
          void'(exp_q.pop_front()); void'(req_q.pop_front());
        end
      end
      if (st_valid) begin
        if (exp_q.size() == 0 || !exp_q[0].is_store) begin
          total++; bad++;
          $display("FAIL R7: unexpected store actual=%h:%h expected=none", st_addr, st_value);
        end else begin
          chk({req_q[0], " addr"}, st_addr, exp_q[0].a);
          chk({req_q[0], " data"}, st_value, exp_q[0].v);
          void'(exp_q.pop_front()); void'(req_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R2 reset pc", pc_o, 32'd0);
    peek(5'd1, 32'd0, "R2 reset regs");

    // Data image (R12).
    load(1'b1, 0, 32'h1234_5678);
    load(1'b1, 1, 32'hFFFF_0000);
    // Program.
    load(1'b0, 0,  enc_i(6'h0D, 5'd0, 5'd1, 16'h8001));   // ori r1
    load(1'b0, 1,  enc_i(6'h23, 5'd0, 5'd2, 16'h0004));   // lw r2, 4(r0)
    load(1'b0, 2,  enc_r(5'd1, 5'd2, 5'd3, 6'h20));       // add r3
    load(1'b0, 3,  enc_r(5'd1, 5'd2, 5'd4, 6'h22));       // sub r4
    load(1'b0, 4,  enc_i(6'h0D, 5'd1, 5'd0, 16'h0005));   // ori r0 (dropped)
    load(1'b0, 5,  enc_i(6'h2B, 5'd0, 5'd3, 16'h0008));   // sw r3, 8(r0)
    load(1'b0, 6,  enc_i(6'h0D, 5'd0, 5'd10, 16'h000C));  // ori r10 = 12
    load(1'b0, 7,  enc_i(6'h23, 5'd10, 5'd5, 16'hFFFC));  // lw r5, -4(r10)
    load(1'b0, 8,  enc_i(6'h04, 5'd1, 5'd2, 16'h0005));   // beq not taken
    load(1'b0, 9,  enc_i(6'h04, 5'd3, 5'd5, 16'h0002));   // beq taken -> 12
    load(1'b0, 10, enc_i(6'h0D, 5'd0, 5'd6, 16'hDEAD));
    load(1'b0, 11, enc_i(6'h0D, 5'd0, 5'd6, 16'hBEEF));
    load(1'b0, 12, {6'h02, 26'd15});                      // j 15
    load(1'b0, 13, enc_i(6'h0D, 5'd0, 5'd7, 16'h0001));
    load(1'b0, 14, enc_i(6'h0D, 5'd0, 5'd7, 16'h0002));
    load(1'b0, 15, enc_i(6'h3F, 5'd0, 5'd9, 16'h1111));   // unknown opcode
    load(1'b0, 16, enc_r(5'd1, 5'd2, 5'd9, 6'h2A));       // unknown funct
    load(1'b0, 17, enc_i(6'h0D, 5'd0, 5'd8, 16'h0077));   // ori r8
    load(1'b0, 18, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));   // beq self
    @(posedge clk); #1;
    ld_en = 1'b0;

    push_w(5'd1,  32'h0000_8001, "R4 ori zero-extend");
    push_w(5'd2,  32'hFFFF_0000, "R6 R12 lw");
    push_w(5'd3,  32'hFFFF_8001, "R1 R5 add");
    push_w(5'd4,  32'h0001_8001, "R1 R5 sub");
    push_s(32'd8, 32'hFFFF_8001, "R7 sw");
    push_w(5'd10, 32'd12,        "R4 ori");
    push_w(5'd5,  32'hFFFF_8001, "R6 lw negative offset");
    push_w(5'd8,  32'h0000_0077, "R10 resume after unknown");

    monitoring = 1;
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    monitoring = 0;

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R11: pending commits actual=%0d expected=0", exp_q.size());
    end
    chk("R8 backward branch holds pc", pc_o, 32'd72);
    peek(5'd0, 32'd0,        "R3 r0 stays zero");
    peek(5'd6, 32'd0,        "R8 taken branch skipped code");
    peek(5'd7, 32'd0,        "R9 jump skipped code");
    peek(5'd9, 32'd0,        "R10 unknown encodings write nothing");
    peek(5'd1, 32'h0000_8001, "R4 r1 via debug");
    peek(5'd5, 32'hFFFF_8001, "R6 r5 via debug");

    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R2 pc after second reset", pc_o, 32'd0);
    peek(5'd8, 32'd0, "R2 regs cleared");

    done = 1;
    summary();
  end
endmodule